// File: doc/BRIEF.md
# Chip-Select Framed Serial Segment Loader

This block takes display contents from a host over a three-wire serial link: an active-low chip select, a serial clock and a data line. It runs on a fast system clock. Both link clocks and the data line pass through multi-flop synchronisers, and the block finds the clock and select edges by oversampling them. Serial bits are gathered into bytes. Each complete byte goes to the next of a fixed set of holding registers: first the digit-segment registers, one per digit, and then one register that carries the special segments and the mode bits.

A falling edge on chip select starts a frame and clears the bit and byte counters. The host may end a frame after any whole byte. Registers the frame did not reach keep their old contents, so a host can refresh the first digits only. The registers drive the multiplex waveform logic in parallel. The control register is split into named fields for that logic.

Top module: `seg_loader`

## Requirements
- R1: After reset every digit register, the special-segment field, the mode field and the sync bit read zero.
- R2: A bit is taken on each rising serial clock edge while chip select is low. In a digit register, bit 7 holds the first bit shifted in (segment H) and bit 0 holds the eighth (segment A).
- R3: Within a frame, bytes fill digit 1, digit 2, up to digit NUM_DIGITS, and then the control register. Each byte writes exactly one register. Digit k occupies digits_o[8k-1:8k-8].
- R4: In shift order the control byte carries SP1, SP2, SP3, SP4, one unused bit, Q6, Q7 and SYNC. special_o[0] is SP1 and special_o[3] is SP4. mode_o is {Q7,Q6}. sync_o is SYNC.
- R5: When chip select rises after a whole byte, registers past the last one written keep their previous value.
- R6: Bits of an unfinished byte at chip select rise are never written to any register.
- R7: A chip select falling edge clears both counters, so the next whole byte lands in digit 1 with correct bit alignment.
- R8: Serial clock edges while chip select is high change no register.
- R9: Bytes beyond the control byte in one frame are ignored until the next chip select falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| digits_o | output | 8*NUM_DIGITS | Digit segment registers, digit 1 in the low byte |
| special_o | output | 4 | Special segments, SP1 in bit 0 |
| mode_o | output | 2 | {Q7,Q6} mode bits |
| sync_o | output | 1 | Synchronisation bit |

## Verification
The bench ends frames early: after two bytes, after a byte plus three stray bits, and after six bytes. A design that steered by a counter not cleared on select fall would put the next byte into the wrong digit or misalign its bits. A design that flushed partial bytes would corrupt a register. A design without a frame cap would let the sixth byte overwrite digit 1. Serial clock pulses while select is high catch a design that shifts without gating. A fully loaded control byte with asymmetric bits exposes reversed field order.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

   localparam int unsigned BYTE_BITS   = 8;
   localparam int unsigned NUM_SPECIAL = 4;

   typedef struct packed {
      logic [NUM_SPECIAL-1:0] special; // bit0 = SP1
      logic [1:0]             mode;    // {Q7,Q6}
      logic                   sync;
   } ctrl_fields_t;

   // Control byte as held: bit7 first shifted (SP1) ... bit0 last (SYNC)
   function automatic ctrl_fields_t decode_ctrl(input logic [BYTE_BITS-1:0] b);
      ctrl_fields_t f;
      for (int i = 0; i < NUM_SPECIAL; i++) begin
         f.special[i] = b[BYTE_BITS-1-i];
      end
      f.mode = {b[1], b[2]};
      f.sync = b[0];
      return f;
   endfunction

endpackage

// File: rtl/seg_loader_sync.sv
module seg_loader_sync #(
   parameter int unsigned WIDTH     = 1,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("seg_loader_sync: STAGES must be at least 2");
      end
   endgenerate

   for (genvar w = 0; w < WIDTH; w++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= {STAGES{RST_VAL[w]}};
         else         chain_q <= {chain_q[STAGES-2:0], d_i[w]};
      end
      assign q_o[w] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/seg_loader_frontend.sv
module seg_loader_frontend #(
   parameter int unsigned BITS      = 8,
   parameter int unsigned NUM_BYTES = 5,
   localparam int unsigned BIT_W    = $clog2(BITS),
   localparam int unsigned BYTE_W   = $clog2(NUM_BYTES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_n_s_i,
   input  logic              sck_s_i,
   input  logic              sdi_s_i,
   output logic              byte_valid_o,
   output logic [BITS-1:0]   byte_data_o,
   output logic [BYTE_W-1:0] byte_idx_o
);

   localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BITS - 1);
   localparam logic [BYTE_W-1:0] CAP      = BYTE_W'(NUM_BYTES);

   logic              cs_n_q, sck_q;
   logic              cs_fall, sck_rise, frame_full, take_bit;
   logic [BIT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0] byte_cnt_q;
   logic [BITS-1:0]   shreg_q;
   logic [BITS-1:0]   next_shreg;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_n_q <= 1'b1;
         sck_q  <= 1'b0;
      end else begin
         cs_n_q <= cs_n_s_i;
         sck_q  <= sck_s_i;
      end
   end

   assign cs_fall    = cs_n_q & ~cs_n_s_i;
   assign sck_rise   = sck_s_i & ~sck_q & ~cs_n_s_i;
   assign frame_full = (byte_cnt_q == CAP);
   assign take_bit   = sck_rise & ~frame_full & ~cs_fall;
   assign next_shreg = {shreg_q[BITS-2:0], sdi_s_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt_q  <= '0;
         byte_cnt_q <= '0;
         shreg_q    <= '0;
      end else if (cs_fall) begin
         bit_cnt_q  <= '0;
         byte_cnt_q <= '0;
      end else if (take_bit) begin
         shreg_q <= next_shreg;
         if (bit_cnt_q == LAST_BIT) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= byte_cnt_q + 1'b1;
         end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
         end
      end
   end

   assign byte_valid_o = take_bit & (bit_cnt_q == LAST_BIT);
   assign byte_data_o  = next_shreg;
   assign byte_idx_o   = byte_cnt_q;

   assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_fall |=> (bit_cnt_q == '0 && byte_cnt_q == '0));

   assert_idle_when_deselected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n_s_i |-> !byte_valid_o);

   assert_frame_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_cnt_q <= CAP);

endmodule

// File: rtl/seg_loader_bank.sv
module seg_loader_bank #(
   parameter int unsigned BITS       = 8,
   parameter int unsigned NUM_DIGITS = 4,
   localparam int unsigned NUM_BYTES = NUM_DIGITS + 1,
   localparam int unsigned BYTE_W    = $clog2(NUM_BYTES + 1)
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       byte_valid_i,
   input  logic [BITS-1:0]            byte_data_i,
   input  logic [BYTE_W-1:0]          byte_idx_i,
   output logic [NUM_DIGITS*BITS-1:0] digits_o,
   output logic [BITS-1:0]            ctrl_o
);

   logic [NUM_BYTES-1:0] wr_en;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
      logic [BITS-1:0] slot_q;
      assign wr_en[g] = byte_valid_i & (byte_idx_i == BYTE_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       slot_q <= '0;
         else if (wr_en[g]) slot_q <= byte_data_i;
      end
      if (g < NUM_DIGITS) begin : g_digit
         assign digits_o[g*BITS +: BITS] = slot_q;
      end else begin : g_ctrl
         assign ctrl_o = slot_q;
      end
   end

   assert_one_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(wr_en));

   assert_hold_without_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !byte_valid_i |=> ($stable(digits_o) && $stable(ctrl_o)));

   assert_index_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_valid_i |-> (byte_idx_i < BYTE_W'(NUM_BYTES)));

endmodule

// File: rtl/seg_loader.sv
module seg_loader
   import seg_loader_pkg::*;
#(
   parameter int unsigned NUM_DIGITS  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            cs_ni,
   input  logic                            sck_i,
   input  logic                            sdi_i,
   output logic [NUM_DIGITS*BYTE_BITS-1:0] digits_o,
   output logic [NUM_SPECIAL-1:0]          special_o,
   output logic [1:0]                      mode_o,
   output logic                            sync_o
);

   localparam int unsigned NUM_BYTES = NUM_DIGITS + 1;
   localparam int unsigned BYTE_W    = $clog2(NUM_BYTES + 1);

   generate
      if (NUM_DIGITS < 1) begin : g_bad_digits
         $error("seg_loader: NUM_DIGITS must be at least 1");
      end
   endgenerate

   logic                 cs_n_s, sck_s, sdi_s;
   logic                 byte_valid;
   logic [BYTE_BITS-1:0] byte_data;
   logic [BYTE_W-1:0]    byte_idx;
   logic [BYTE_BITS-1:0] ctrl_raw;
   ctrl_fields_t         ctrl_f;

   seg_loader_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({cs_ni, sck_i, sdi_i}),
      .q_o    ({cs_n_s, sck_s, sdi_s})
   );

   seg_loader_frontend #(
      .BITS      (BYTE_BITS),
      .NUM_BYTES (NUM_BYTES)
   ) u_front (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cs_n_s_i     (cs_n_s),
      .sck_s_i      (sck_s),
      .sdi_s_i      (sdi_s),
      .byte_valid_o (byte_valid),
      .byte_data_o  (byte_data),
      .byte_idx_o   (byte_idx)
   );

   seg_loader_bank #(
      .BITS       (BYTE_BITS),
      .NUM_DIGITS (NUM_DIGITS)
   ) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .byte_valid_i (byte_valid),
      .byte_data_i  (byte_data),
      .byte_idx_i   (byte_idx),
      .digits_o     (digits_o),
      .ctrl_o       (ctrl_raw)
   );

   assign ctrl_f    = decode_ctrl(ctrl_raw);
   assign special_o = ctrl_f.special;
   assign mode_o    = ctrl_f.mode;
   assign sync_o    = ctrl_f.sync;

   assert_reset_clear_R1: assert property (@(posedge clk_i)
      !rst_ni |-> (digits_o == '0 && special_o == '0 && mode_o == '0 && !sync_o));

endmodule

// File: tb/seg_loader_tb.sv
module seg_loader_tb;

   localparam int ND = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cs_n = 1'b1;
   logic            sck = 1'b0;
   logic            sdi = 1'b0;
   logic [ND*8-1:0] digits;
   logic [3:0]      special;
   logic [1:0]      mode;
   logic            sync_b;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   seg_loader #(.NUM_DIGITS(ND)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
      .digits_o(digits), .special_o(special), .mode_o(mode), .sync_o(sync_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sck = 1'b0;
         sdi = b[7-i];
         wait_clks(8);
         sck = 1'b1;
         wait_clks(8);
         sck = 1'b0;
      end
   endtask

   task automatic frame_start();
      @(negedge clk);
      cs_n = 1'b1;
      wait_clks(8);
      cs_n = 1'b0;
      wait_clks(8);
   endtask

   task automatic frame_end();
      @(negedge clk);
      cs_n = 1'b1;
      wait_clks(16);
   endtask

   function automatic logic [7:0] dig(input int k);
      return digits[(k-1)*8 +: 8];
   endfunction

   task automatic t_reset();
      check("R1 digits", digits, '0);
      check("R1 ctrl", {special, mode, sync_b}, '0);
   endtask

   task automatic t_full_load();
      // control: SP1=1 SP2=0 SP3=1 SP4=1 x=0 Q6=1 Q7=0 SYNC=1 -> 8'hB5
      frame_start();
      send_bits(8'hA5, 8);
      send_bits(8'h3C, 8);
      send_bits(8'h81, 8);
      send_bits(8'h7E, 8);
      send_bits(8'hB5, 8);
      frame_end();
      check("R2 digit1 order", dig(1), 8'hA5);
      check("R3 digit2", dig(2), 8'h3C);
      check("R3 digit3", dig(3), 8'h81);
      check("R3 digit4", dig(4), 8'h7E);
      check("R4 special", special, 4'b1101);
      check("R4 mode", mode, 2'b01);
      check("R4 sync", sync_b, 1'b1);
   endtask

   task automatic t_partial_frame();
      frame_start();
      send_bits(8'h11, 8);
      send_bits(8'h22, 8);
      frame_end();
      check("R5 digit1", dig(1), 8'h11);
      check("R5 digit2", dig(2), 8'h22);
      check("R5 digit3 kept", dig(3), 8'h81);
      check("R5 digit4 kept", dig(4), 8'h7E);
      check("R5 ctrl kept", {special, mode, sync_b}, {4'b1101, 2'b01, 1'b1});
   endtask

   task automatic t_stray_bits();
      frame_start();
      send_bits(8'h5A, 8);
      send_bits(8'hFF, 3);
      frame_end();
      check("R6 digit1", dig(1), 8'h5A);
      check("R6 digit2 untouched", dig(2), 8'h22);
      frame_start();
      send_bits(8'hC3, 8);
      frame_end();
      check("R7 realigned digit1", dig(1), 8'hC3);
      check("R7 digit2 untouched", dig(2), 8'h22);
   endtask

   task automatic t_deselected_clock();
      @(negedge clk);
      cs_n = 1'b1;
      send_bits(8'hFF, 8);
      send_bits(8'h00, 8);
      wait_clks(16);
      check("R8 digits", digits, {8'h7E, 8'h81, 8'h22, 8'hC3});
      check("R8 ctrl", {special, mode, sync_b}, {4'b1101, 2'b01, 1'b1});
   endtask

   task automatic t_overrun();
      frame_start();
      send_bits(8'h01, 8);
      send_bits(8'h02, 8);
      send_bits(8'h04, 8);
      send_bits(8'h08, 8);
      send_bits(8'h06, 8); // SP all 0, Q6=1, Q7=1, SYNC=0
      send_bits(8'hEE, 8);
      frame_end();
      check("R9 digit1 not overwritten", dig(1), 8'h01);
      check("R9 digit4", dig(4), 8'h08);
      check("R9 ctrl", {special, mode, sync_b}, {4'b0000, 2'b11, 1'b0});
   endtask

   initial begin
      wait_clks(4);
      rst_n = 1'b1;
      wait_clks(4);
      t_reset();
      t_full_load();
      t_partial_frame();
      t_stray_bits();
      t_deselected_clock();
      t_overrun();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #3_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule